// File: doc/BRIEF.md
# Token-Ring Acquisition and Readout Sequencer

This block is the per-chip controller of a self-triggered front-end readout. It steps through four phases: idle, acquisition, conversion and readout. During acquisition, each self-trigger takes the next free memory slot. The slot records the current bunch-crossing number and the pattern of channels that fired. The trigger then stays disarmed until the next bunch-crossing tick. During conversion, the block asks an external converter to digitise each filled slot in order, and it captures the returned charge, fine time and gain bit.

Readout is shared with other chips through a daisy-chained token. A chip in its readout phase waits for the token. It then shifts its chip number and its stored events onto one serial line and hands the token to the next chip. A chip that recorded nothing passes the token on at once and sends no bits. The analog memory and the converter are outside the block.

Top module: `tring_seq`

## Requirements
- R1: After reset the block is idle: `ram_full`, `tx_on`, `ser_out`, `token_out`, `end_readout` and `conv_req` are 0, and `no_trig` is 1.
- R2: `start_acq` in idle enters acquisition, empties all slots, sets the bunch counter to 0 and arms the trigger. `stop_acq` in acquisition ends it. `start_acq` outside idle and `stop_acq` outside acquisition are ignored.
- R3: In acquisition (not in a `stop_acq` cycle), an armed trigger with any bit of `trig_hits` set stores the current bunch counter and `trig_hits` in the next slot and disarms. An all-zero `trig_hits` is not a trigger.
- R4: A disarmed trigger ignores hits until a `bx_tick`. A hit in the same cycle as a `bx_tick` records the counter value from before the increment, and the trigger is armed again for the next crossing.
- R5: Each `bx_tick` in acquisition increments the 8-bit bunch counter, wrapping from 255 to 0.
- R6: `ram_full` is 1 when all 16 slots hold events, and further triggers are then ignored until the next `start_acq`. `no_trig` is 1 while no slot holds an event.
- R7: After `stop_acq` with at least one event, `conv_req` is held with `conv_slot` equal to 0, 1, and so on. Each `conv_done` captures `conv_charge`, `conv_fine` and `conv_gain` for that slot and moves to the next slot. After the last slot, the block goes to readout. With no events, the block enters readout directly.
- R8: Transmission starts only on a `token_in` received in the readout phase. `token_in` in any other phase, or during a transmission, is ignored and is not forwarded.
- R9: A transmission starts the cycle after `token_in`. It is the 8-bit `chip_id` MSB first, then each event in slot order as a 69-bit word MSB first: bunch counter [68:61], hit pattern [60:25], gain [24], fine time [23:12], charge [11:0]. `tx_on` is 1 exactly while these bits are on `ser_out`, and `ser_out` is 0 otherwise.
- R10: `token_out` and `end_readout` pulse for one cycle, right after the last bit is sent, or for an empty chip the cycle after `token_in`. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id | input | 8 | Chip number sent ahead of the events |
| start_acq | input | 1 | Begin an acquisition |
| stop_acq | input | 1 | End an acquisition |
| bx_tick | input | 1 | Bunch-crossing boundary pulse |
| trig_hits | input | 36 | Per-channel trigger pattern |
| conv_req | output | 1 | Conversion request for `conv_slot` |
| conv_slot | output | 4 | Slot being converted |
| conv_done | input | 1 | Converter result valid |
| conv_charge | input | 12 | Converted charge |
| conv_fine | input | 12 | Converted fine time |
| conv_gain | input | 1 | Shaper gain used |
| token_in | input | 1 | Token from the previous chip |
| token_out | output | 1 | Token to the next chip |
| ser_out | output | 1 | Serial data |
| tx_on | output | 1 | Serial data valid |
| end_readout | output | 1 | Readout finished pulse |
| ram_full | output | 1 | All slots used |
| no_trig | output | 1 | No event stored |

## Verification
The trigger path is driven with isolated hits, hits while disarmed, hits on the same cycle as a tick, all-zero patterns and a burst of twenty triggers. These separate correct rearming from tick-coincident bunch tagging and from overflow once sixteen slots are used. A long run of ticks before a trigger shows whether the bunch counter wraps. Readout is tried with one event, several events, sixteen events and none. Each serial bit is compared against a model-built stream, so framing errors, off-by-one event counts and a token that is passed too early or too late show up at the bit where they occur.

// File: rtl/tring_pkg.sv
package tring_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACQ  = 2'd1,
      PH_CONV = 2'd2,
      PH_READ = 2'd3
   } phase_t;
endpackage

// File: rtl/tring_slot_alloc.sv
module tring_slot_alloc #(
   parameter int DEPTH  = 16,
   parameter int NCH    = 36,
   parameter int BCID_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              acq_en,
   input  logic              bx_tick,
   input  logic [NCH-1:0]    hits,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic [BCID_W-1:0] rd_bcid,
   output logic [NCH-1:0]    rd_hits
);
   logic              armed;
   logic [BCID_W-1:0] bcid;
   logic              take;
   logic [BCID_W-1:0] s_bcid [DEPTH];
   logic [NCH-1:0]    s_hits [DEPTH];

   assign full = (count == CNT_W'(DEPTH));
   assign take = acq_en && armed && (|hits) && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         bcid  <= '0;
         count <= '0;
      end else if (clear) begin
         armed <= 1'b1;
         bcid  <= '0;
         count <= '0;
      end else if (acq_en) begin
         if (bx_tick) begin
            armed <= 1'b1;
            bcid  <= bcid + 1'b1;
         end else if (take) begin
            armed <= 1'b0;
         end
         if (take) count <= count + 1'b1;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (take && count == CNT_W'(g)) begin
            s_bcid[g] <= bcid;
            s_hits[g] <= hits;
         end
      end
   end

   assign rd_bcid = s_bcid[rd_idx];
   assign rd_hits = s_hits[rd_idx];

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clear) |=> full); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (count == $past(count) || count == $past(count) + 1'b1)); // R3
   AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !clear) |=> (count == $past(count))); // R4
   AST_BCID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_en && bx_tick && !clear) |=> (bcid == $past(bcid) + 1'b1)); // R5
endmodule

// File: rtl/tring_conv_walk.sv
module tring_conv_walk #(
   parameter int DEPTH = 16,
   parameter int ADC_W = 12,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] n,
   input  logic             conv_done,
   input  logic [ADC_W-1:0] charge,
   input  logic [ADC_W-1:0] fine,
   input  logic             gain,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             conv_req,
   output logic [IDX_W-1:0] conv_slot,
   output logic             last,
   output logic [ADC_W-1:0] rd_charge,
   output logic [ADC_W-1:0] rd_fine,
   output logic             rd_gain
);
   logic             active;
   logic [IDX_W-1:0] idx;
   logic [ADC_W-1:0] r_charge [DEPTH];
   logic [ADC_W-1:0] r_fine   [DEPTH];
   logic             r_gain   [DEPTH];

   assign conv_req  = active;
   assign conv_slot = idx;
   assign last      = active && conv_done && (CNT_W'(idx) + 1'b1 == n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (active && conv_done) begin
         if (last) active <= 1'b0;
         else      idx    <= idx + 1'b1;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_res
      always_ff @(posedge clk) begin
         if (active && conv_done && idx == IDX_W'(g)) begin
            r_charge[g] <= charge;
            r_fine[g]   <= fine;
            r_gain[g]   <= gain;
         end
      end
   end

   assign rd_charge = r_charge[rd_idx];
   assign rd_fine   = r_fine[rd_idx];
   assign rd_gain   = r_gain[rd_idx];

   AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (CNT_W'(conv_slot) < n)); // R7
   AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_done && !last && !start) |=> (conv_req && conv_slot == $past(conv_slot) + 1'b1)); // R7
endmodule

// File: rtl/tring_ser_tx.sv
module tring_ser_tx #(
   parameter int DEPTH = 16,
   parameter int EVW   = 69,
   parameter int ID_W  = 8,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CNT_W-1:0] n,
   input  logic [ID_W-1:0]  chip_id,
   input  logic [EVW-1:0]   rd_word,
   output logic [IDX_W-1:0] rd_idx,
   output logic             busy,
   output logic             ser_out,
   output logic             done
);
   localparam int BL_W = $clog2(EVW + 1);

   logic [EVW-1:0]   sreg;
   logic [BL_W-1:0]  bits_left;
   logic [CNT_W-1:0] ev_next;

   assign rd_idx  = ev_next[IDX_W-1:0];
   assign ser_out = busy & sreg[EVW-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         sreg      <= '0;
         bits_left <= '0;
         ev_next   <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            if (n == '0) begin
               done <= 1'b1;
            end else begin
               busy      <= 1'b1;
               sreg      <= {chip_id, {(EVW - ID_W){1'b0}}};
               bits_left <= BL_W'(ID_W);
               ev_next   <= '0;
            end
         end else if (busy) begin
            if (bits_left == BL_W'(1)) begin
               if (ev_next < n) begin
                  sreg      <= rd_word;
                  bits_left <= BL_W'(EVW);
                  ev_next   <= ev_next + 1'b1;
               end else begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  sreg <= '0;
               end
            end else begin
               sreg      <= {sreg[EVW-2:0], 1'b0};
               bits_left <= bits_left - 1'b1;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_TOKEN_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |-> 1'b0); // R8
endmodule

// File: rtl/tring_seq.sv
module tring_seq
   import tring_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int NCH    = 36,
   parameter int BCID_W = 8,
   parameter int ADC_W  = 12,
   parameter int ID_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ID_W-1:0]          chip_id,
   input  logic                     start_acq,
   input  logic                     stop_acq,
   input  logic                     bx_tick,
   input  logic [NCH-1:0]           trig_hits,
   output logic                     conv_req,
   output logic [$clog2(DEPTH)-1:0] conv_slot,
   input  logic                     conv_done,
   input  logic [ADC_W-1:0]         conv_charge,
   input  logic [ADC_W-1:0]         conv_fine,
   input  logic                     conv_gain,
   input  logic                     token_in,
   output logic                     token_out,
   output logic                     ser_out,
   output logic                     tx_on,
   output logic                     end_readout,
   output logic                     ram_full,
   output logic                     no_trig
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int EVW   = BCID_W + NCH + 1 + 2 * ADC_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("tring_seq: DEPTH must be at least 2");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("tring_seq: NCH must be at least 1");
   end
   if (EVW <= ID_W) begin : g_bad_evw
      $error("tring_seq: event word must be wider than chip id");
   end

   phase_t phase;
   logic [CNT_W-1:0]  count;
   logic              clear, acq_en, conv_go, conv_last, go, done;
   logic [IDX_W-1:0]  rd_idx;
   logic [BCID_W-1:0] a_bcid;
   logic [NCH-1:0]    a_hits;
   logic [ADC_W-1:0]  c_charge, c_fine;
   logic              c_gain;
   logic [EVW-1:0]    rd_word;

   assign clear   = (phase == PH_IDLE) && start_acq;
   assign acq_en  = (phase == PH_ACQ) && !stop_acq;
   assign conv_go = (phase == PH_ACQ) && stop_acq && (count != '0);
   assign go      = (phase == PH_READ) && token_in && !tx_on && !done;
   assign rd_word = {a_bcid, a_hits, c_gain, c_fine, c_charge};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE: if (start_acq) phase <= PH_ACQ;
            PH_ACQ:  if (stop_acq)  phase <= (count == '0) ? PH_READ : PH_CONV;
            PH_CONV: if (conv_last) phase <= PH_READ;
            PH_READ: if (done)      phase <= PH_IDLE;
            default:                phase <= PH_IDLE;
         endcase
      end
   end

   tring_slot_alloc #(
      .DEPTH(DEPTH), .NCH(NCH), .BCID_W(BCID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .clear(clear), .acq_en(acq_en),
      .bx_tick(bx_tick), .hits(trig_hits), .rd_idx(rd_idx),
      .count(count), .full(ram_full), .rd_bcid(a_bcid), .rd_hits(a_hits)
   );

   tring_conv_walk #(
      .DEPTH(DEPTH), .ADC_W(ADC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_conv (
      .clk(clk), .rst_n(rst_n), .start(conv_go), .n(count),
      .conv_done(conv_done), .charge(conv_charge), .fine(conv_fine),
      .gain(conv_gain), .rd_idx(rd_idx), .conv_req(conv_req),
      .conv_slot(conv_slot), .last(conv_last), .rd_charge(c_charge),
      .rd_fine(c_fine), .rd_gain(c_gain)
   );

   tring_ser_tx #(
      .DEPTH(DEPTH), .EVW(EVW), .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .go(go), .n(count), .chip_id(chip_id),
      .rd_word(rd_word), .rd_idx(rd_idx), .busy(tx_on),
      .ser_out(ser_out), .done(done)
   );

   assign token_out   = done;
   assign end_readout = done;
   assign no_trig     = (count == '0);

   AST_TOKEN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      token_out |-> (phase == PH_READ)); // R8
   AST_CONV_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (phase == PH_CONV)); // R7
   AST_TX_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      tx_on |-> (phase == PH_READ)); // R9
   AST_IDLE_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
      token_out |=> (phase == PH_IDLE)); // R10
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (no_trig && !ram_full)); // R2
endmodule

// File: tb/sim_tring_seq.sv
module sim_tring_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  chip_id = 8'hA5;
   logic        start_acq = 1'b0, stop_acq = 1'b0, bx_tick = 1'b0, token_in = 1'b0;
   logic [35:0] trig_hits = '0;
   logic        conv_done = 1'b0, conv_gain = 1'b0;
   logic [11:0] conv_charge = '0, conv_fine = '0;
   logic        conv_req, token_out, ser_out, tx_on, end_readout, ram_full, no_trig;
   logic [3:0]  conv_slot;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   tring_seq u0 (
      .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .start_acq(start_acq),
      .stop_acq(stop_acq), .bx_tick(bx_tick), .trig_hits(trig_hits),
      .conv_req(conv_req), .conv_slot(conv_slot), .conv_done(conv_done),
      .conv_charge(conv_charge), .conv_fine(conv_fine), .conv_gain(conv_gain),
      .token_in(token_in), .token_out(token_out), .ser_out(ser_out),
      .tx_on(tx_on), .end_readout(end_readout), .ram_full(ram_full),
      .no_trig(no_trig)
   );

   // behavioural reference model
   int          m_ph = 0;
   int          m_bcid = 0;
   bit          m_armed = 0;
   logic [43:0] ev_q[$];
   bit          ev_co[$];
   int          m_cidx = 0;
   logic [24:0] m_res[16];
   bit          bits_q[$];
   int          tag_q[$];
   bit          m_send = 0, m_tok = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic build_stream();
      bits_q.delete();
      tag_q.delete();
      for (int b = 7; b >= 0; b--) begin bits_q.push_back(chip_id[b]); tag_q.push_back(9); end
      for (int i = 0; i < ev_q.size(); i++) begin
         logic [68:0] w;
         w = {ev_q[i], m_res[i]};
         for (int b = 68; b >= 0; b--) begin
            bits_q.push_back(w[b]);
            if (b >= 61)      tag_q.push_back(ev_co[i] ? 4 : 5);
            else if (b >= 25) tag_q.push_back(3);
            else              tag_q.push_back(7);
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_bcid = 0; m_armed = 0; ev_q.delete(); ev_co.delete();
         m_cidx = 0; m_send = 0; m_tok = 0; bits_q.delete(); tag_q.delete();
      end else begin
         case (m_ph)
            0: if (start_acq) begin
                  m_ph = 1; m_bcid = 0; m_armed = 1; ev_q.delete(); ev_co.delete();
               end
            1: if (stop_acq) begin
                  m_ph = (ev_q.size() == 0) ? 3 : 2; m_cidx = 0;
               end else begin
                  if (m_armed && trig_hits != 0 && ev_q.size() < 16) begin
                     ev_q.push_back({m_bcid[7:0], trig_hits});
                     ev_co.push_back(bx_tick);
                     m_armed = 0;
                  end
                  if (bx_tick) begin m_armed = 1; m_bcid = (m_bcid + 1) % 256; end
               end
            2: if (conv_done) begin
                  m_res[m_cidx] = {conv_gain, conv_fine, conv_charge};
                  if (m_cidx == ev_q.size() - 1) m_ph = 3; else m_cidx++;
               end
            default: begin
               if (m_tok) begin
                  m_tok = 0; m_ph = 0;
               end else if (m_send) begin
                  void'(bits_q.pop_front());
                  void'(tag_q.pop_front());
                  if (bits_q.size() == 0) begin m_send = 0; m_tok = 1; end
               end else if (token_in) begin
                  build_stream();
                  if (ev_q.size() == 0) m_tok = 1; else m_send = 1;
               end
            end
         endcase
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(ram_full == (ev_q.size() == 16), "R6", "ram_full", ram_full, ev_q.size() == 16);
         chk(no_trig == (ev_q.size() == 0), "R6", "no_trig", no_trig, ev_q.size() == 0);
         chk(conv_req == (m_ph == 2), "R7", "conv_req", conv_req, m_ph == 2);
         if (m_ph == 2)
            chk(conv_slot == m_cidx[3:0], "R7", "conv_slot", conv_slot, m_cidx);
         chk(tx_on == m_send, "R9", "tx_on", tx_on, m_send);
         if (m_send)
            chk(ser_out == bits_q[0], $sformatf("R%0d", tag_q[0]), "ser_out", ser_out, bits_q[0]);
         else
            chk(ser_out == 1'b0, "R9", "ser_out idle", ser_out, 0);
         chk(token_out == m_tok, (m_ph == 3) ? "R10" : "R8", "token_out", token_out, m_tok);
         chk(end_readout == m_tok, "R10", "end_readout", end_readout, m_tok);
      end
   end

   // converter responder: answers every other cycle
   initial begin
      bit tgl = 0;
      forever begin
         @(negedge clk);
         tgl = ~tgl;
         if (conv_req && tgl) begin
            conv_done   = 1'b1;
            conv_charge = 12'(conv_slot * 97 + 13);
            conv_fine   = 12'(conv_slot * 53 + 400);
            conv_gain   = conv_slot[0];
         end else begin
            conv_done = 1'b0;
         end
      end
   end

   task automatic step(bit s, bit p, bit t, logic [35:0] h, bit k);
      start_acq = s; stop_acq = p; bx_tick = t; trig_hits = h; token_in = k;
      @(negedge clk);
      start_acq = 0; stop_acq = 0; bx_tick = 0; trig_hits = '0; token_in = 0;
   endtask

   task automatic finish_read();
      step(0, 1, 0, '0, 0);
      while (m_ph != 3) @(negedge clk);
      @(negedge clk);
      step(0, 0, 0, '0, 1);
      while (m_ph != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!ram_full && no_trig && !tx_on && !ser_out && !token_out && !end_readout && !conv_req,
          "R1", "reset outputs", {ram_full, no_trig, tx_on, ser_out, token_out, conv_req}, 6'b010000);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 token in idle is ignored
      step(0, 0, 0, '0, 1);
      chk(token_out == 0 && tx_on == 0, "R8", "token in idle", token_out, 0);

      // R3 R4 R5 mixed trigger patterns
      step(1, 0, 0, '0, 0);
      step(0, 0, 0, 36'h000000020, 0);
      step(0, 0, 0, 36'h000000100, 0);
      step(0, 0, 1, '0, 0);
      step(0, 0, 1, 36'h800000001, 0);
      step(0, 0, 0, '0, 0);
      step(0, 0, 0, 36'h0F0F0F0F0, 0);
      step(0, 1, 0, '0, 0);
      step(0, 0, 0, '0, 1);
      while (m_ph != 3) @(negedge clk);
      @(negedge clk);
      step(0, 0, 0, '0, 1);
      while (m_ph != 0) @(negedge clk);
      @(negedge clk);

      // R6 overflow burst, R2 restart ignored during acquisition
      step(1, 0, 0, '0, 0);
      for (int i = 0; i < 20; i++) step(0, 0, 1, 36'(i + 1), 0);
      step(1, 0, 0, '0, 0);
      chk(ram_full == 1 && no_trig == 0, "R2", "start ignored in acquisition", {ram_full, no_trig}, 2'b10);
      finish_read();

      // R10 empty chip passes token at once
      step(1, 0, 0, '0, 0);
      step(0, 0, 1, '0, 0);
      finish_read();

      // R5 bunch counter wrap
      step(1, 0, 0, '0, 0);
      for (int i = 0; i < 260; i++) step(0, 0, 1, '0, 0);
      step(0, 0, 0, 36'hF00000001, 0);
      finish_read();

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule